// File: doc/BRIEF.md
# Per-Pin Byte-Addressed GPIO Register Bank

This block is a memory-mapped general-purpose I/O bank of 8 ports with 32 pins each, 256 pins in all. Pins carry one linear number, `port*32 + pin`, and each one has a byte address of its own in a low "pin region." Software can therefore read or change the level of any single pin with one byte access, without a read-modify-write of a shared word. Each port also has a 32-bit direction word in a separate region starting at offset 0x2000. These words decide which pins are driven.

The block keeps one output-value register and one direction register for each pin. It drives `pin_out` and `pin_oe` straight from these registers. The input pins pass through a two-flop synchroniser before they can be read. The output register keeps its value while the pin is an input, so software can write the level first and then turn on the driver, and the pin never shows a stale level. The bus is a single-cycle synchronous strobe interface. Writes take effect at the clock edge. Read data is registered and is valid on the cycle after the read strobe.

Top module: `gpio_byte_bank`

## Requirements
- R1: After reset every `pin_oe` bit is 0 (all inputs), every `pin_out` bit is 0, and `bus_rdata` is 0.
- R2: A write to pin-region offset n (0 to 255) loads bit 0 of `bus_wdata` into the output register of pin n. Bits 31:1 of the write data are ignored, and no other pin's output register changes.
- R3: A read of pin-region offset n returns 0x00000000 or 0x00000001 on `bus_rdata` in the cycle after the strobe. The value is the output-register bit when pin n is an output (direction bit 1), and the synchronised input level when it is an input (direction bit 0).
- R4: `pin_out[n]` always shows pin n's output register, including while the pin is an input. A value written while the pin is an input is driven unchanged once its direction bit is set, and writing a direction word never changes any output register.
- R5: The 32-bit direction word of port p sits at offset 0x2000 + 4*p (p = 0 to 7). Bit i drives `pin_oe[p*32+i]` (1 = output, 0 = input), and a read of that offset returns the word.
- R6: `pin_in` passes through two flip-flops. A read strobe in the first clock edge after an input change still returns the old level, and a read issued two edges later returns the new one.
- R7: An access outside both regions reads as zero and a write to it changes no register. This covers offsets 0x100 to 0x1FFF, offsets from 0x2020 upward, and direction-region offsets not a multiple of 4.
- R8: Pin numbering is linear across ports. Offset 37 addresses port 1 bit 5, and offsets 0 and 255 address the first and last pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte offset of the access |
| bus_wdata | input | 32 | Write data (bit 0 only for pin offsets) |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| pin_in | input | 256 | Asynchronous pin input levels |
| pin_out | output | 256 | Output-value register of each pin |
| pin_oe | output | 256 | Output enable of each pin |

## Verification
The hardest case to reach from the ports is the synchroniser latency, because it only shows when a read lands in the exact cycle after an input changes. The bench changes `pin_in` and issues the read strobe at the same falling edge, expects the old level, and then reads again two cycles later for the new one. A second hard case is a value held while the pin is an input. It is reached by writing the level first, checking that the pin still reads its input, and then setting the direction bit and checking both the pin read and `pin_out`. Out-of-range writes are checked by comparing every output and enable bit before and after.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PIN  = 2'd1,
    ACC_DIR  = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 256,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stage_d[s] = din;
      end else begin : g_rest
        assign stage_d[s] = stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W        = 14,
  parameter int NUM_PORTS     = 8,
  parameter int PINS_PER_PORT = 32,
  parameter int DIR_BASE      = 'h2000
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [$clog2(NUM_PORTS)-1:0]     port_idx,
  output logic [$clog2(PINS_PER_PORT)-1:0] pin_idx
);

  localparam int PIN_W    = $clog2(PINS_PER_PORT);
  localparam int PORT_W   = $clog2(NUM_PORTS);
  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;
  localparam int DIR_SPAN = NUM_PORTS * 4;

  logic [ADDR_W-1:0] dir_off;
  logic              in_pin;
  logic              in_dir;

  always_comb begin
    dir_off  = addr - ADDR_W'(DIR_BASE);
    in_pin   = (int'(addr) < NUM_PINS);
    in_dir   = (int'(addr) >= DIR_BASE) && (int'(dir_off) < DIR_SPAN)
               && (addr[1:0] == 2'b00);
    kind     = ACC_NONE;
    port_idx = '0;
    pin_idx  = '0;
    if (in_pin) begin
      kind     = ACC_PIN;
      port_idx = addr[PIN_W+PORT_W-1:PIN_W];
      pin_idx  = addr[PIN_W-1:0];
    end else if (in_dir) begin
      kind     = ACC_DIR;
      port_idx = dir_off[PORT_W+1:2];
    end
  end

endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice #(
  parameter int PINS_PER_PORT = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             pin_we,
  input  logic [$clog2(PINS_PER_PORT)-1:0] pin_idx,
  input  logic                             pin_wbit,
  input  logic                             dir_we,
  input  logic [PINS_PER_PORT-1:0]         dir_wdata,
  input  logic [PINS_PER_PORT-1:0]         sync_in,
  output logic [PINS_PER_PORT-1:0]         out_q,
  output logic [PINS_PER_PORT-1:0]         dir_q,
  output logic [PINS_PER_PORT-1:0]         level
);

  logic [PINS_PER_PORT-1:0] out_d;
  logic [PINS_PER_PORT-1:0] dir_d;

  always_comb begin
    out_d = out_q;
    if (pin_we) begin
      out_d[pin_idx] = pin_wbit;
    end
  end

  always_comb begin
    dir_d = dir_q;
    if (dir_we) begin
      dir_d = dir_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (pin_we) begin
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_we) begin
      dir_q <= dir_d;
    end
  end

  generate
    for (genvar i = 0; i < PINS_PER_PORT; i++) begin : g_level
      assign level[i] = dir_q[i] ? out_q[i] : sync_in[i];
    end
  endgenerate

  // R2: the addressed bit takes the written value
  a_r2_pin_write: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pin_we) |-> (out_q[$past(pin_idx)] == $past(pin_wbit)));

  // R4: a direction update leaves output values alone
  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && !pin_we) |=> $stable(out_q));

endmodule

// File: rtl/gpio_byte_bank.sv
module gpio_byte_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS     = 8,
  parameter int PINS_PER_PORT = 32,
  parameter int ADDR_W        = 14,
  parameter int DIR_BASE      = 'h2000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 bus_sel,
  input  logic                                 bus_wr,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic [PINS_PER_PORT-1:0]             bus_wdata,
  output logic [PINS_PER_PORT-1:0]             bus_rdata,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0]   pin_in,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]   pin_out,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]   pin_oe
);

  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;
  localparam int PIN_W    = $clog2(PINS_PER_PORT);
  localparam int PORT_W   = $clog2(NUM_PORTS);
  localparam int DW       = PINS_PER_PORT;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q = rst_pipe[1];

  // input synchroniser
  logic [NUM_PINS-1:0] sync_in;

  gpio_in_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .din   (pin_in),
    .dout  (sync_in)
  );

  // address decode
  acc_kind_e         kind;
  logic [PORT_W-1:0] port_idx;
  logic [PIN_W-1:0]  pin_idx;

  gpio_addr_decode #(
    .ADDR_W        (ADDR_W),
    .NUM_PORTS     (NUM_PORTS),
    .PINS_PER_PORT (PINS_PER_PORT),
    .DIR_BASE      (DIR_BASE)
  ) u_dec (
    .addr     (bus_addr),
    .kind     (kind),
    .port_idx (port_idx),
    .pin_idx  (pin_idx)
  );

  logic wr_en;
  logic rd_en;
  assign wr_en = bus_sel &&  bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  // per-port registers
  logic [NUM_PORTS-1:0]         pin_we;
  logic [NUM_PORTS-1:0]         dir_we;
  logic [NUM_PORTS-1:0][DW-1:0] out_q;
  logic [NUM_PORTS-1:0][DW-1:0] dir_q;
  logic [NUM_PORTS-1:0][DW-1:0] level;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign pin_we[p] = wr_en && (kind == ACC_PIN) && (port_idx == PORT_W'(p));
      assign dir_we[p] = wr_en && (kind == ACC_DIR) && (port_idx == PORT_W'(p));

      gpio_port_slice #(
        .PINS_PER_PORT (PINS_PER_PORT)
      ) u_slice (
        .clk       (clk),
        .rst_n     (rst_q),
        .pin_we    (pin_we[p]),
        .pin_idx   (pin_idx),
        .pin_wbit  (bus_wdata[0]),
        .dir_we    (dir_we[p]),
        .dir_wdata (bus_wdata),
        .sync_in   (sync_in[p*DW +: DW]),
        .out_q     (out_q[p]),
        .dir_q     (dir_q[p]),
        .level     (level[p])
      );

      assign pin_out[p*DW +: DW] = out_q[p];
      assign pin_oe[p*DW +: DW]  = dir_q[p];
    end
  endgenerate

  // registered read path
  logic [DW-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    unique case (kind)
      ACC_PIN:  rdata_d = {{(DW-1){1'b0}}, level[port_idx][pin_idx]};
      ACC_DIR:  rdata_d = dir_q[port_idx];
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      bus_rdata <= rdata_d;
    end
  end

  // R3: pin reads return only 0 or 1
  a_r3_pin_read_bit: assert property (@(posedge clk) disable iff (!rst_q)
    $past(rd_en && (kind == ACC_PIN)) |-> (bus_rdata[DW-1:1] == '0));

  // R5: enables move only on a direction write
  a_r5_oe_only_on_dir: assert property (@(posedge clk) disable iff (!rst_q)
    !(|dir_we) |=> $stable(pin_oe));

  // R7: unmapped reads return zero
  a_r7_unmapped_read: assert property (@(posedge clk) disable iff (!rst_q)
    $past(rd_en && (kind == ACC_NONE)) |-> (bus_rdata == '0));

  // R7: unmapped writes leave every register unchanged
  a_r7_unmapped_write: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && (kind == ACC_NONE)) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/gpio_byte_bank_test.sv
module gpio_byte_bank_test;

  localparam int NPINS = 256;

  logic              clk;
  logic              rst_n;
  logic              bus_sel;
  logic              bus_wr;
  logic [13:0]       bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [NPINS-1:0]  pin_in;
  logic [NPINS-1:0]  pin_out;
  logic [NPINS-1:0]  pin_oe;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  gpio_byte_bank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check32(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_wide(input string req, input string what,
                            input logic [NPINS-1:0] act, input logic [NPINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic bus_write(input logic [13:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [13:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check_wide("R1", "pin_oe after reset", pin_oe, '0);
    check_wide("R1", "pin_out after reset", pin_out, '0);
    check32("R1", "rdata after reset", bus_rdata, 32'h0);
  endtask

  task automatic t_pin_write;
    logic [NPINS-1:0] exp_out;
    exp_out = '0;
    bus_write(14'd37, 32'hFFFF_FFFF);   // bit0=1
    exp_out[37] = 1'b1;
    check_wide("R2", "pin 37 set, others intact", pin_out, exp_out);
    bus_write(14'd38, 32'hFFFF_FFFE);   // bit0=0
    check_wide("R2", "upper data bits ignored on pin 38", pin_out, exp_out);
    bus_write(14'd0, 32'h1);
    bus_write(14'd255, 32'h1);
    exp_out[0] = 1'b1; exp_out[255] = 1'b1;
    check_wide("R8", "first and last pin", pin_out, exp_out);
    check_wide("R4", "enables still clear", pin_oe, '0);
  endtask

  task automatic t_hold_then_drive;
    logic [31:0] d;
    bus_read(14'd37, d);
    check32("R3", "input pin 37 reads synced input", d, 32'h0);
    bus_write(14'h2004, 32'h0000_0020);   // port 1 bit 5
    check32("R5", "oe of pin 37", {31'b0, pin_oe[37]}, 32'h1);
    check32("R4", "held value driven", {31'b0, pin_out[37]}, 32'h1);
    check32("R8", "only port1 bit5 enabled", pin_oe[63:32], 32'h0000_0020);
    bus_read(14'd37, d);
    check32("R3", "output pin 37 reads register", d, 32'h1);
    bus_read(14'h2004, d);
    check32("R5", "direction word readback", d, 32'h0000_0020);
    bus_write(14'h2004, 32'h0);
    check32("R4", "dir write keeps out bit", {31'b0, pin_out[37]}, 32'h1);
  endtask

  task automatic t_inputs;
    logic [31:0] d;
    pin_in[200] = 1'b1;
    idle(4);
    bus_read(14'd200, d);
    check32("R3", "input pin 200 high", d, 32'h1);
    bus_write(14'h201C, 32'hFFFF_FFFF);
    check32("R5", "port 7 all outputs", pin_oe[255:224], 32'hFFFF_FFFF);
    bus_read(14'd255, d);
    check32("R8", "pin 255 as output", d, 32'h1);
    bus_read(14'd254, d);
    check32("R3", "pin 254 output reg low", d, 32'h0);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    pin_in[3] = 1'b1;
    bus_read(14'd3, d);
    check32("R6", "first-edge read sees old level", d, 32'h0);
    idle(1);
    bus_read(14'd3, d);
    check32("R6", "later read sees new level", d, 32'h1);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    logic [NPINS-1:0] o0, e0;
    o0 = pin_out; e0 = pin_oe;
    bus_write(14'h0100, 32'h1);
    bus_write(14'h2001, 32'hFFFF_FFFF);
    bus_write(14'h2020, 32'hFFFF_FFFF);
    bus_write(14'h1FFF, 32'h1);
    check_wide("R7", "outputs untouched", pin_out, o0);
    check_wide("R7", "enables untouched", pin_oe, e0);
    bus_read(14'h201C, d);           // nonzero first
    bus_read(14'h0100, d);
    check32("R7", "read 0x100", d, 32'h0);
    bus_read(14'h201E, d);
    check32("R7", "misaligned dir read", d, 32'h0);
    bus_read(14'h2020, d);
    check32("R7", "past dir region", d, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_pin_write();
    t_hold_then_drive();
    t_inputs();
    t_sync();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule